// File: doc/BRIEF.md
# Multi-channel compare match timer

The block holds several independent timer channels behind one small register bus. Each channel counts edges of a divided system clock. Software picks one of three division ratios for each channel. A 16-bit counter climbs until it equals the channel's compare value. On the next count edge the channel records a match, sets its match flag and returns the counter to zero. The match period is therefore the compare value plus one count edges.

A per-channel mode field routes each match to a CPU interrupt line, to a DMA transfer request, or to nothing. The low-numbered channels, two by default, issue a single-cycle DMA request for every match. The remaining channels raise a DMA request that stays high until the DMA controller reports that its programmed transfer amount is done. The request then falls with no software action. The interrupt line follows the match flag, and only a software write of 0 clears the flag.

Each channel occupies four word addresses. The address is the channel index times four plus a register offset: 0 for control/status, 1 for the counter, 2 for the compare value, and 3, which reads as 0.

Top module: `cmp_timer_array`

## Requirements
- R1: After reset every control, counter and compare register reads 0, and all `irq` and `dreq` outputs are low.
- R2: Control bits [3:1] select the count clock. Value 0 gives one count edge per 8 system clocks, value 1 gives one per 32, and any other value gives one per 128. From a reset divider phase, the first count edge falls on the Nth clock edge after the edge that sets the run bit, where N is the division ratio.
- R3: A count edge taken while the counter equals the compare value is a match, and the counter becomes 0 on that edge. A channel started at counter 0 therefore first matches (compare+1)×N clock edges after the start.
- R4: Control bit 0 is the run bit. While it is 0, the counter and the divider phase hold, and counting resumes from the held phase.
- R5: Control bits [5:4] set the request mode: 00 gives no request, 01 gives DMA request, 10 gives interrupt, and 11 gives no request. In every mode a match still sets the flag.
- R6: Control bit 7 is the match flag, set by a match. The channel's `irq` output is high while the flag is set and the mode is 10. A control write with bit 7 at 0 clears the flag, and a write with bit 7 at 1 leaves it unchanged. A match on the same edge as a clearing write leaves the flag set.
- R7: On channels below NSHOT, in DMA mode, each match drives that channel's `dreq` high for exactly one clock cycle, starting on the match edge.
- R8: On channels NSHOT and above, in DMA mode, `dreq` rises on the match edge and stays high until the first clock edge at which that channel's `dma_done` input is high.
- R9: The counter and compare registers can be written and read back at any time. A counter write on the same edge as a count edge stores the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address: channel×4 + register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| dma_done | input | 5 | Per channel: DMA transfer amount reached |
| dreq | output | 5 | Per channel DMA transfer request |
| irq | output | 5 | Per channel interrupt request |

## Verification
The hardest situations to reach are a bus write that lands exactly on an internal count edge. One case is a clearing write to the flag on a match edge. The other is a counter write on an increment edge. Neither edge is visible at the ports. The stimulus starts from a fresh reset, so the divider phase is zero. It starts the channel with a known write, counts clock edges from that write, and places the second write on the computed count edge. The results are then read back: the flag must still be set, and the counter must hold the written value rather than a value one higher.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_DMA  = 2'b01,
    REQ_IRQ  = 2'b10,
    REQ_RSV  = 2'b11
  } req_mode_e;

  localparam int REG_CTRL = 0;
  localparam int REG_CNT  = 1;
  localparam int REG_CMP  = 2;

  localparam int CTL_RUN  = 0;
  localparam int CTL_CKS  = 1;
  localparam int CTL_MODE = 4;
  localparam int CTL_FLAG = 7;

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int LOG_A = 3,
  parameter int LOG_B = 5,
  parameter int LOG_C = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] cks,
  output logic       tick
);
  localparam int PRE_W = LOG_C;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pre_en;

  always_comb begin
    pre_en = run;
    pre_d  = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  always_comb begin
    case (cks)
      3'd0:    tick = run && (&pre_q[LOG_A-1:0]);
      3'd1:    tick = run && (&pre_q[LOG_B-1:0]);
      default: tick = run && (&pre_q[LOG_C-1:0]);
    endcase
  end

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pre_q));

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/cmt_dreq.sv
module cmt_dreq #(
  parameter bit ONE_SHOT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic dma_mode,
  input  logic dma_done,
  output logic dreq
);
  logic dreq_q, dreq_d;

  generate
    if (ONE_SHOT) begin : g_pulse
      always_comb dreq_d = match && dma_mode;

      // R7
      single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_q |=> !dreq_q);
    end else begin : g_hold
      always_comb dreq_d = dma_mode && (match || (dreq_q && !dma_done));

      // R8
      held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_q && dma_mode && !dma_done |=> dreq_q);

      // R8
      done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_q && dma_done && !match |=> !dreq_q);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreq_q <= 1'b0;
    else        dreq_q <= dreq_d;
  end

  assign dreq = dreq_q;

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CW       = 16,
  parameter bit ONE_SHOT = 1'b1,
  parameter int LOG_A    = 3,
  parameter int LOG_B    = 5,
  parameter int LOG_C    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          cnt_we,
  input  logic          cmp_we,
  input  logic [CW-1:0] wdata,
  input  logic          dma_done,
  output logic [7:0]    ctrl_rd,
  output logic [CW-1:0] cnt_rd,
  output logic [CW-1:0] cmp_rd,
  output logic          irq,
  output logic          dreq
);
  logic          run_q, run_d;
  logic [2:0]    cks_q, cks_d;
  req_mode_e     mode_q, mode_d;
  logic          flag_q, flag_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cmp_q, cmp_d;
  logic          tick, match;

  cmt_prescaler #(.LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .cks  (cks_q),
    .tick (tick)
  );

  assign match = tick && (cnt_q == cmp_q);

  always_comb begin
    run_d  = run_q;
    cks_d  = cks_q;
    mode_d = mode_q;
    flag_d = flag_q;
    cmp_d  = cmp_q;
    cnt_d  = cnt_q;
    if (ctrl_we) begin
      run_d  = wdata[CTL_RUN];
      cks_d  = wdata[CTL_CKS +: 3];
      mode_d = req_mode_e'(wdata[CTL_MODE +: 2]);
      if (!wdata[CTL_FLAG]) flag_d = 1'b0;
    end
    if (match) flag_d = 1'b1;
    if (cmp_we) cmp_d = wdata;
    if (cnt_we)     cnt_d = wdata;
    else if (match) cnt_d = '0;
    else if (tick)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cks_q  <= '0;
      mode_q <= REQ_NONE;
      flag_q <= 1'b0;
      cnt_q  <= '0;
      cmp_q  <= '0;
    end else begin
      run_q  <= run_d;
      cks_q  <= cks_d;
      mode_q <= mode_d;
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
    end
  end

  cmt_dreq #(.ONE_SHOT(ONE_SHOT)) u_dreq (
    .clk     (clk),
    .rst_n   (rst_n),
    .match   (match),
    .dma_mode(mode_q == REQ_DMA),
    .dma_done(dma_done),
    .dreq    (dreq)
  );

  assign irq     = flag_q && (mode_q == REQ_IRQ);
  assign ctrl_rd = {flag_q, 1'b0, mode_q, cks_q, run_q};
  assign cnt_rd  = cnt_q;
  assign cmp_rd  = cmp_q;

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q);

  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !(ctrl_we && !wdata[CTL_FLAG]) |=> flag_q);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_we && (cnt_q != cmp_q) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match && !cnt_we |=> cnt_q == '0);

  // R9
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(wdata));

endmodule

// File: rtl/cmt_regbus.sv
module cmt_regbus
  import cmt_pkg::*;
#(
  parameter int NCH = 5,
  parameter int CW  = 16,
  parameter int AW  = 5
) (
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  output logic [CW-1:0]           bus_rdata,
  input  logic [NCH-1:0][7:0]     ctrl_rd,
  input  logic [NCH-1:0][CW-1:0]  cnt_rd,
  input  logic [NCH-1:0][CW-1:0]  cmp_rd,
  output logic [NCH-1:0]          ctrl_we,
  output logic [NCH-1:0]          cnt_we,
  output logic [NCH-1:0]          cmp_we
);
  logic [AW-3:0] ch_idx;
  logic [1:0]    reg_off;

  assign ch_idx  = bus_addr[AW-1:2];
  assign reg_off = bus_addr[1:0];

  always_comb begin
    ctrl_we   = '0;
    cnt_we    = '0;
    cmp_we    = '0;
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (bus_sel && (int'(ch_idx) == c)) begin
        if (bus_wr) begin
          ctrl_we[c] = (int'(reg_off) == REG_CTRL);
          cnt_we[c]  = (int'(reg_off) == REG_CNT);
          cmp_we[c]  = (int'(reg_off) == REG_CMP);
        end else begin
          case (int'(reg_off))
            REG_CTRL: bus_rdata = CW'(ctrl_rd[c]);
            REG_CNT:  bus_rdata = cnt_rd[c];
            REG_CMP:  bus_rdata = cmp_rd[c];
            default:  bus_rdata = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/cmp_timer_array.sv
module cmp_timer_array #(
  parameter int NCH   = 5,
  parameter int NSHOT = 2,
  parameter int CW    = 16,
  parameter int LOG_A = 3,
  parameter int LOG_B = 5,
  parameter int LOG_C = 7,
  parameter int AW    = $clog2(NCH) + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  input  logic [NCH-1:0] dma_done,
  output logic [NCH-1:0] dreq,
  output logic [NCH-1:0] irq
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [NCH-1:0][7:0]    ctrl_rd;
  logic [NCH-1:0][CW-1:0] cnt_rd, cmp_rd;
  logic [NCH-1:0]         ctrl_we, cnt_we, cmp_we;

  cmt_regbus #(.NCH(NCH), .CW(CW), .AW(AW)) u_bus (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .ctrl_rd  (ctrl_rd),
    .cnt_rd   (cnt_rd),
    .cmp_rd   (cmp_rd),
    .ctrl_we  (ctrl_we),
    .cnt_we   (cnt_we),
    .cmp_we   (cmp_we)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      cmt_channel #(
        .CW      (CW),
        .ONE_SHOT(g < NSHOT),
        .LOG_A   (LOG_A),
        .LOG_B   (LOG_B),
        .LOG_C   (LOG_C)
      ) u_ch (
        .clk     (clk),
        .rst_n   (rst_n_s),
        .ctrl_we (ctrl_we[g]),
        .cnt_we  (cnt_we[g]),
        .cmp_we  (cmp_we[g]),
        .wdata   (bus_wdata),
        .dma_done(dma_done[g]),
        .ctrl_rd (ctrl_rd[g]),
        .cnt_rd  (cnt_rd[g]),
        .cmp_rd  (cmp_rd[g]),
        .irq     (irq[g]),
        .dreq    (dreq[g])
      );
    end
  endgenerate

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_s |-> (irq == '0) && (dreq == '0));

endmodule

// File: tb/test_cmp_timer_array.sv
`timescale 1ns/1ps
module test_cmp_timer_array;
  localparam int NCH = 5;
  localparam int AW  = 5;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bus_sel, bus_wr;
  logic [AW-1:0]  bus_addr;
  logic [15:0]    bus_wdata, bus_rdata;
  logic [NCH-1:0] dma_done, dreq, irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cmp_timer_array i_cmp_timer_array (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_done(dma_done), .dreq(dreq), .irq(irq)
  );

  // columns: channel, clock select, compare value, expected edges to first match
  localparam int VEC [4][4] = '{
    '{0, 0, 3, 32},
    '{1, 1, 2, 96},
    '{3, 2, 1, 256},
    '{4, 5, 3, 512}
  };

  task automatic chk(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; dma_done = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic wr(input int ch, input int off, input int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(ch*4 + off); bus_wdata = 16'(d);
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output int v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(ch*4 + off);
    #1 v = int'(bus_rdata);
    bus_sel = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v, a, n, hi, dbl;
    do_reset();

    // R1 reset state
    rd(0, 0, v); chk("R1 ctrl0", v, 0);
    rd(4, 1, v); chk("R1 cnt4", v, 0);
    rd(2, 2, v); chk("R1 cmp2", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dreq", int'(dreq), 0);

    // R2 R3 table: interrupt mode, period per clock select
    for (int i = 0; i < 4; i++) begin
      do_reset();
      wr(VEC[i][0], 2, VEC[i][2]);
      wr(VEC[i][0], 0, 32'h20 | (VEC[i][1] << 1) | 1);
      n = 0;
      while (!irq[VEC[i][0]] && n < 2000) begin
        @(posedge clk); #1 n++;
      end
      chk("R2/R3 match edge count", n, VEC[i][3]);
      rd(VEC[i][0], 1, v); chk("R3 counter wraps to 0", v, 0);
    end

    // R6 write 1 keeps flag, match on clear edge keeps flag, plain clear clears
    do_reset();
    wr(1, 0, 32'h21);                 // cmp=0, div 8, irq mode, run
    repeat (15) @(posedge clk);
    wr(1, 0, 32'h21);                 // clearing write on second match edge
    rd(1, 0, v); chk("R6 match beats clear", (v >> 7) & 1, 1);
    wr(1, 0, 32'hA0);                 // stop, bit7=1: no effect
    rd(1, 0, v); chk("R6 write 1 no effect", (v >> 7) & 1, 1);
    chk("R6 irq high", int'(irq[1]), 1);
    wr(1, 0, 32'h20);                 // bit7=0 clears
    rd(1, 0, v); chk("R6 clear", (v >> 7) & 1, 0);
    chk("R6 irq low", int'(irq[1]), 0);

    // R9 counter write on a count edge wins
    do_reset();
    wr(2, 2, 32'hFFFF);
    wr(2, 0, 32'h01);
    repeat (7) @(posedge clk);
    wr(2, 1, 100);
    rd(2, 1, v); chk("R9 write beats increment", v, 100);
    rd(2, 2, v); chk("R9 compare readback", v, 32'hFFFF);

    // R7 one-shot DMA on channel 0
    do_reset();
    wr(0, 2, 1);
    wr(0, 0, 32'h11);                 // DMA mode, div 8, run
    hi = 0; dbl = 0;
    for (int k = 0; k < 64; k++) begin
      @(posedge clk); #1;
      if (dreq[0]) begin
        if (hi > 0 && k > 0 && a == k - 1) dbl++;
        hi++; a = k;
      end
    end
    chk("R7 pulses in 64 edges", hi, 4);
    chk("R7 pulse width one", dbl, 0);
    chk("R5 no irq in DMA mode", int'(irq[0]), 0);

    // R8 held DMA on channel 2
    do_reset();
    wr(2, 0, 32'h11);                 // cmp=0, DMA mode, run
    repeat (8) @(posedge clk);
    hi = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (dreq[2]) hi++;
    end
    chk("R8 request held", hi, 40);
    wr(2, 0, 32'h10);                 // stop, keep DMA mode
    chk("R8 still high before done", int'(dreq[2]), 1);
    @(negedge clk) dma_done[2] = 1'b1;
    @(posedge clk); #1;
    chk("R8 drops on done", int'(dreq[2]), 0);
    dma_done[2] = 1'b0;

    // R5 reserved mode: flag sets, no request
    do_reset();
    wr(3, 0, 32'h31);
    repeat (20) @(posedge clk);
    #1;
    chk("R5 reserved no irq", int'(irq[3]), 0);
    chk("R5 reserved no dreq", int'(dreq[3]), 0);
    rd(3, 0, v); chk("R5 flag still set", v, 32'hB1);

    // R4 stop holds counter and divider phase
    do_reset();
    wr(4, 2, 32'hFFFF);
    wr(4, 0, 32'h01);
    repeat (30) @(posedge clk);
    wr(4, 0, 32'h00);
    rd(4, 1, a); chk("R4 count at stop", a, 3);
    repeat (50) @(posedge clk);
    rd(4, 1, v); chk("R4 count held", v, a);
    wr(4, 0, 32'h01);
    @(posedge clk); #1;
    rd(4, 1, v); chk("R4 phase resumes", v, 4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule